// File: doc/BRIEF.md
# Serial Memory Bus Addressing Front End

This block sits at the bus edge of a two-wire serial memory slave. It oversamples the clock and data lines with a faster system clock and waits for a Start condition. After that it collects the select byte and checks it against two accepted type codes and three board-strapped chip-enable inputs. When the byte matches, it pulls the data line low for the acknowledge slot. It then takes in two address bytes, high byte first, and acknowledges each one.

After the last address acknowledge, the block presents the 16-bit address with a one-cycle valid strobe. With it come the region that was selected (main array or identification page) and the transfer direction. Any mismatch, and any Stop, sends the block back to idle until the next Start. A Start at any point, including a repeated Start in the middle of a byte, restarts select-byte reception.

Top module: `i2c_mem_addr_frontend`

## Requirements
- R1: During and straight after reset the block does not pull the data line low, and `addr_valid` is 0.
- R2: A select byte (bits sent MSB first) whose upper nibble is 1010b and whose bits 3..1 equal `chip_sel[2:0]` is acknowledged, and `id_region` then reads 0 (main array).
- R3: A select byte whose upper nibble is 1011b, with a chip-enable match, is acknowledged, and `id_region` then reads 1 (identification page).
- R4: A select byte with any other upper nibble is not acknowledged. The bytes that follow before the next Start are not acknowledged either, and no `addr_valid` pulse occurs.
- R5: A select byte whose bits 3..1 differ from `chip_sel` is not acknowledged, and no `addr_valid` pulse occurs before the next Start.
- R6: Bit 0 of an accepted select byte sets `rd_nwr`: 1 for read, 0 for write.
- R7: After an accepted select byte, each of the two following bytes is acknowledged. `addr` equals {first byte, second byte}.
- R8: `addr_valid` pulses for exactly one clock, once per transaction, after the falling SCL edge that ends the acknowledge of the second address byte. `addr`, `id_region` and `rd_nwr` are valid in that cycle.
- R9: A Start received mid-byte or between address bytes discards the transfer in progress and restarts select-byte reception.
- R10: The data line is pulled low only in the acknowledge slot. The pull begins after the SCL fall that ends bit 8 and ends after the SCL fall that ends bit 9, so it changes only while SCL is low.
- R11: A Stop returns the block to idle. Bytes sent afterwards without a new Start are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level (wired, including this block's own drive) |
| chip_sel | input | 3 | Board-strapped chip-enable levels |
| sda_drive_low | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_valid | output | 1 | One-cycle strobe: address phase complete |
| addr | output | 16 | Received memory address |
| id_region | output | 1 | 1 = identification page, 0 = main array |
| rd_nwr | output | 1 | 1 = read, 0 = write |

## Verification
All sixteen type nibbles are sent with matching chip-enable bits and both direction values. This separates the two accepted codes from each other (by the region flag) and from the fourteen rejected ones (by the missing acknowledge and strobe). A full sweep over all eight strap values against all eight select values, using the main array code, separates a chip-enable match from every single- and multi-bit mismatch. Each address pair is computed from the loop indices, so a swapped or shifted byte shows up as a wrong `addr`. Separate sequences cover a repeated Start mid-byte, a repeated Start between address bytes, and a Stop followed by bytes with no new Start.

// File: rtl/i2c_mem_addr_frontend.sv
module i2c_mem_addr_frontend #(
  parameter logic [3:0] MEM_TYPE = 4'b1010,
  parameter logic [3:0] ID_TYPE  = 4'b1011
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic [2:0]  chip_sel,
  output logic        sda_drive_low,
  output logic        addr_valid,
  output logic [15:0] addr,
  output logic        id_region,
  output logic        rd_nwr
);
  localparam int BITS = 8;

  typedef enum logic [1:0] {S_IDLE, S_SEL, S_AHI, S_ALO} st_t;

  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       ack;

  wire scl = scl_sync[1];
  wire sda = sda_sync[1];
  wire start_seen = scl_q && scl && sda_q && !sda;
  wire stop_seen  = scl_q && scl && !sda_q && sda;
  wire scl_rise   = !scl_q && scl;
  wire scl_fall   = scl_q && !scl;
  wire type_ok    = (shreg[7:4] == MEM_TYPE) || (shreg[7:4] == ID_TYPE);
  wire sel_match  = type_ok && (shreg[3:1] == chip_sel);

  assign sda_drive_low = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_in};
      sda_sync <= {sda_sync[0], sda_in};
      scl_q    <= scl;
      sda_q    <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ack        <= 1'b0;
      addr_valid <= 1'b0;
      addr       <= '0;
      id_region  <= 1'b0;
      rd_nwr     <= 1'b0;
    end else begin
      addr_valid <= 1'b0;
      if (start_seen) begin
        st     <= S_SEL;
        bitcnt <= '0;
        ack    <= 1'b0;
      end else if (stop_seen) begin
        st  <= S_IDLE;
        ack <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && bitcnt < 4'(BITS)) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall && ack) begin
          ack    <= 1'b0;
          bitcnt <= '0;
          case (st)
            S_SEL:   st <= S_AHI;
            S_AHI:   st <= S_ALO;
            default: begin
              st         <= S_IDLE;
              addr_valid <= 1'b1;
            end
          endcase
        end else if (scl_fall && bitcnt == 4'(BITS)) begin
          case (st)
            S_SEL: begin
              if (sel_match) begin
                ack       <= 1'b1;
                id_region <= (shreg[7:4] == ID_TYPE);
                rd_nwr    <= shreg[0];
              end else begin
                st <= S_IDLE;
              end
            end
            S_AHI: begin
              ack         <= 1'b1;
              addr[15:8]  <= shreg;
            end
            default: begin
              ack        <= 1'b1;
              addr[7:0]  <= shreg;
            end
          endcase
        end
      end
    end
  end
endmodule

module i2c_mem_addr_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic sda_drive_low,
  input logic addr_valid,
  input logic id_region
);
  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (!sda_drive_low && !addr_valid);

  assert_ack_edge_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_in);

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);

  assert_valid_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> !sda_drive_low);

  assert_region_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $stable(id_region));
endmodule

bind i2c_mem_addr_frontend i2c_mem_addr_frontend_chk u_chk (.*);

// File: tb/i2c_mem_addr_frontend_test.sv
module i2c_mem_addr_frontend_test;
  localparam int Q = 6;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [2:0] pins = 3'd0;
  logic sda_drive_low, addr_valid, id_region, rd_nwr;
  logic [15:0] addr;
  wire sda_line = sda_m & ~sda_drive_low;

  int checks = 0, errors = 0, vcnt = 0;
  logic [15:0] cap_addr;
  logic cap_region, cap_rw;
  bit done = 0;

  always #10 clk = ~clk;

  i2c_mem_addr_frontend uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .chip_sel(pins),
    .sda_drive_low(sda_drive_low), .addr_valid(addr_valid), .addr(addr),
    .id_region(id_region), .rd_nwr(rd_nwr));

  always @(negedge clk)
    if (addr_valid) begin
      vcnt++;
      cap_addr = addr;
      cap_region = id_region;
      cap_rw = rd_nwr;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(H);
    sda_m = 1'b0; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(Q); scl = 1'b1; wt(H); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ackd,
                           output logic pre, output logic post);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(H);
      if (i == 0) pre = sda_drive_low;
      scl = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(H / 2);
    ackd = sda_drive_low;
    wt(H / 2); scl = 1'b0; wt(Q);
    post = sda_drive_low;
  endtask

  task automatic txn(input logic [3:0] t, input logic [2:0] c, input logic rw,
                     input logic [7:0] hi, input logic [7:0] lo);
    logic a0, a1, a2, pre, post, exp_ack;
    exp_ack = ((t == 4'b1010) || (t == 4'b1011)) && (c == pins);
    vcnt = 0;
    bus_start();
    send_byte({t, c, rw}, a0, pre, post);
    chk("R10 no drive before ack slot", pre, 0);
    chk("R10 drive released after ack slot", post, 0);
    if (t == 4'b1011) chk("R3 id code select ack", a0, exp_ack);
    else if (t == 4'b1010) chk("R2/R5 main code select ack", a0, exp_ack);
    else chk("R4 foreign type select ack", a0, 0);
    send_byte(hi, a1, pre, post);
    send_byte(lo, a2, pre, post);
    wt(Q);
    bus_stop();
    if (exp_ack) begin
      chk("R7 high address ack", a1, 1);
      chk("R7 low address ack", a2, 1);
      chk("R8 one valid pulse", vcnt, 1);
      chk("R7 address value", cap_addr, {hi, lo});
      chk("R2 R3 region flag", cap_region, (t == 4'b1011));
      chk("R6 direction", cap_rw, rw);
    end else begin
      chk("R4 R5 later bytes ignored", a1 | a2, 0);
      chk("R4 R5 no valid pulse", vcnt, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic a, pre, post;
    wt(3);
    chk("R1 reset drive", sda_drive_low, 0);
    chk("R1 reset valid", addr_valid, 0);
    rst_n = 1'b1;
    wt(5);
    chk("R1 after reset drive", sda_drive_low, 0);

    pins = 3'b101;
    for (int t = 0; t < 16; t++)
      for (int rw = 0; rw < 2; rw++)
        txn(4'(t), pins, rw[0], 8'(t * 16 + rw) ^ 8'h5A, 8'(t * 7 + 3));

    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 8; c++) begin
        pins = 3'(p);
        txn(4'b1010, 3'(c), c[0], 8'(p * 8 + c), 8'(c * 37 + p));
      end

    // R9: repeated start mid-byte
    pins = 3'b010;
    vcnt = 0;
    bus_start();
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    send_byte({4'b1011, 3'b010, 1'b1}, a, pre, post);
    chk("R9 select after restart mid-byte", a, 1);
    send_byte(8'hC3, a, pre, post);
    send_byte(8'h81, a, pre, post);
    wt(Q);
    chk("R9 valid after restart", vcnt, 1);
    chk("R9 address after restart", cap_addr, 16'hC381);
    bus_stop();

    // R9: repeated start between address bytes
    vcnt = 0;
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a, pre, post);
    send_byte(8'hEE, a, pre, post);
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b1}, a, pre, post);
    chk("R9 select after restart in address", a, 1);
    send_byte(8'h12, a, pre, post);
    send_byte(8'h34, a, pre, post);
    wt(Q);
    chk("R9 single valid", vcnt, 1);
    chk("R9 new address", cap_addr, 16'h1234);
    chk("R9 new direction", cap_rw, 1);
    bus_stop();

    // R11: stop returns to idle
    vcnt = 0;
    bus_start();
    send_byte({4'b1010, 3'b010, 1'b0}, a, pre, post);
    chk("R11 select before stop", a, 1);
    wt(Q);
    bus_stop();
    sda_m = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    send_byte(8'h55, a, pre, post);
    chk("R11 byte after stop ignored", a, 0);
    send_byte({4'b1010, 3'b010, 1'b0}, a, pre, post);
    chk("R11 select without start ignored", a, 0);
    wt(Q);
    chk("R11 no valid", vcnt, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule